// File: doc/BRIEF.md
# Status Change Interrupt Aggregator

This block watches the status bits of four channel status registers and tells a host when any of them has moved since the host last read that register. Each status bit has its own mask bit; an unmasked bit that differs from the value last handed out by a read is pending. If anything is pending, the block raises an interrupt pin. The same condition appears as a global bit in a summary register.

The serial port that does the shifting sits outside this block. It opens a read cycle with a register address and closes it when the shifting is done. It gets back the resolved register number and a data word that is frozen for the whole cycle. A reserved address sends the read to the lowest-numbered channel register with a pending change. Repeated reads of that address therefore walk through the pending registers in ascending order. The interrupt drops at the edge that closes the last of them.

Top module: `chg_irq_agg`

## Requirements
- R1: Each status input passes through two flip-flops before change detection. A change on `stat_in`, sampled at one rising edge, makes `irq_pin` high after the third rising edge, counting that one, and not after the second.
- R2: A status bit is pending when its synchronised value differs from the reference value of its channel. The reference is the last data word returned by a completed read of that channel's register, and all zeros after reset.
- R3: A bit whose `mask_in` bit is 1 is never pending. It does not raise `irq_pin` and does not appear in the summary register.
- R4: `irq_pin` is high exactly when some bit is pending. The summary register (address 4) holds the same condition in bit 7, and the per-channel pending flags for channels 0 to 3 in bits 3:0. Bits 6:4 are 0.
- R5: Addresses 0 to 3 return the synchronised status of channel 0 to 3, captured at the edge that opens the read. Any address other than 0 to 4 and 15 returns 0. `rd_reg` shows the resolved address, and `rd_data` holds its value until the next accepted read.
- R6: A read of address 15 while some channel is pending resolves to the lowest-numbered pending channel. `rd_reg` shows that channel's number.
- R7: Successive reads of address 15 visit the pending channels in ascending order, one per read cycle. `irq_pin` stays high until the edge that closes the last pending read, and is low after it.
- R8: A read of address 15 with nothing pending resolves to the summary register (`rd_reg` = 4), with bit 7 at 0.
- R9: Closing a read of channel register c updates only channel c's reference, and only at the closing edge. While the read is open, and for other channels, pending flags stay as they were.
- R10: A status change on a channel that arrives while that channel's read is open stays pending after the read closes.
- R11: `rd_begin` while a read is open, without `rd_finish`, is ignored. With `rd_finish` in the same cycle, the open read closes and the new one opens. For that new read, the closing channel's reference is already updated when the read is resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_in | input | NUM_CH*STAT_W | Asynchronous status bits; channel c in bits [c*STAT_W +: STAT_W] |
| mask_in | input | NUM_CH*STAT_W | Mask bits, same layout as `stat_in`; 1 masks the bit |
| rd_begin | input | 1 | Opens a read cycle at `rd_addr` |
| rd_addr | input | 4 | Requested register address |
| rd_finish | input | 1 | Closes the open read cycle |
| rd_reg | output | 4 | Resolved address of the current read |
| rd_data | output | STAT_W | Data word of the current read, frozen while it is open |
| irq_pin | output | 1 | High while any unmasked change is pending |

## Verification
Two pairs of events can fall in the same cycle. The first is the close of one read and the opening of the next redirected read. The bench raises `rd_finish` and `rd_begin` at address 15 together while channels 0 and 3 are pending, and expects the new read to resolve to channel 3, not to the channel 0 that is being cleared. The second is a status change landing while that same channel's read is open. The bench changes channel 1 in the middle of its read and expects the interrupt and the summary flag for channel 1 to survive the close. A follow-up redirected read must then return channel 1 again, with the new value.

// File: rtl/cia_pkg.sv
package cia_pkg;

    localparam int unsigned ADDR_W = 4;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    // What an accepted read resolved to
    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CHAN = 2'd1,
        RK_SUM  = 2'd2
    } rd_kind_e;

endpackage

// File: rtl/cia_sync.sv
module cia_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/cia_chan.sv
module cia_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat,
    input  logic [W-1:0] mask,
    input  logic         clr,
    input  logic [W-1:0] clr_val,
    output logic [W-1:0] pend
);

    typedef struct packed {
        logic [W-1:0] ref_v;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.ref_v = clr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Pending is judged against the reference as it stands after this edge
    assign pend = (stat ^ st_d.ref_v) & ~mask;

    // R9: the reference moves only when this channel's read closes
    a_r9_ref_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(st_q.ref_v));

endmodule

// File: rtl/cia_pick.sv
module cia_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/chg_irq_agg.sv
module chg_irq_agg
    import cia_pkg::*;
#(
    parameter int        NUM_CH     = 4,
    parameter int        STAT_W     = 8,
    parameter reg_addr_t REDIR_ADDR = 4'd15,
    parameter reg_addr_t SUM_ADDR   = 4'd4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*STAT_W-1:0] stat_in,
    input  logic [NUM_CH*STAT_W-1:0] mask_in,
    input  logic                     rd_begin,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     rd_finish,
    output logic [ADDR_W-1:0]        rd_reg,
    output logic [STAT_W-1:0]        rd_data,
    output logic                     irq_pin
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic              active;
        rd_kind_e          kind;
        logic [CH_W-1:0]   chan;
        reg_addr_t         addr;
        logic [STAT_W-1:0] hold;
        logic              irq;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_CH*STAT_W-1:0] stat_s;
    logic [STAT_W-1:0]        stat_arr [NUM_CH];
    logic [STAT_W-1:0]        pend_arr [NUM_CH];
    logic [NUM_CH-1:0]        ch_pend;
    logic [NUM_CH-1:0]        clr_vec;
    logic                     any_pend;
    logic                     pick_found;
    logic [CH_W-1:0]          pick_idx;
    logic                     accept;

    cia_sync #(.W(NUM_CH*STAT_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stat_in),
        .q     (stat_s)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign stat_arr[c] = stat_s[c*STAT_W +: STAT_W];

        cia_chan #(.W(STAT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .stat    (stat_arr[c]),
            .mask    (mask_in[c*STAT_W +: STAT_W]),
            .clr     (clr_vec[c]),
            .clr_val (st_q.hold),
            .pend    (pend_arr[c])
        );

        assign ch_pend[c] = |pend_arr[c];
    end

    assign any_pend = |ch_pend;

    cia_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
        .req   (ch_pend),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // A channel's reference is refreshed when its read closes
    always_comb begin
        clr_vec = '0;
        if (st_q.active && rd_finish && st_q.kind == RK_CHAN)
            clr_vec[st_q.chan] = 1'b1;
    end

    assign accept = rd_begin && (!st_q.active || rd_finish);

    always_comb begin
        reg_addr_t         res_addr;
        logic [STAT_W-1:0] summ;

        st_d     = st_q;
        st_d.irq = any_pend;
        res_addr = rd_addr;
        summ     = '0;
        summ[NUM_CH-1:0] = ch_pend;
        summ[STAT_W-1]   = any_pend;

        if (st_q.active && rd_finish) st_d.active = 1'b0;

        if (accept) begin
            if (rd_addr == REDIR_ADDR)
                res_addr = pick_found ? ADDR_W'(pick_idx) : SUM_ADDR;
            st_d.active = 1'b1;
            st_d.addr   = res_addr;
            if (int'(res_addr) < NUM_CH) begin
                st_d.kind = RK_CHAN;
                st_d.chan = res_addr[CH_W-1:0];
                st_d.hold = stat_arr[res_addr[CH_W-1:0]];
            end else if (res_addr == SUM_ADDR) begin
                st_d.kind = RK_SUM;
                st_d.hold = summ;
            end else begin
                st_d.kind = RK_NONE;
                st_d.hold = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_reg  = st_q.addr;
    assign rd_data = st_q.hold;
    assign irq_pin = st_q.irq;

    // R3: with every bit masked the pin must stay low
    a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_in) |=> !irq_pin);

    // R4: a summary read carries the same condition as the pin
    a_r4_summary_matches_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rd_addr == SUM_ADDR) |=> (rd_data[STAT_W-1] == irq_pin));

    // R6: a redirected read with something pending lands on a channel
    a_r6_redirect_to_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rd_addr == REDIR_ADDR && any_pend) |=> (int'(rd_reg) < NUM_CH));

    // R8: a redirected read with nothing pending lands on the summary
    a_r8_empty_to_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rd_addr == REDIR_ADDR && !any_pend)
            |=> (rd_reg == SUM_ADDR && !rd_data[STAT_W-1]));

    // R11: an opening request during an open read changes nothing
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && rd_begin && !rd_finish) |=> ($stable(rd_reg) && $stable(rd_data)));

endmodule

// File: tb/chg_irq_agg_bench.sv
module chg_irq_agg_bench;

    localparam int NCH = 4;
    localparam int SW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH*SW-1:0] stat_in = '0;
    logic [NCH*SW-1:0] mask_in = '0;
    logic            rd_begin = 1'b0;
    logic [3:0]      rd_addr = '0;
    logic            rd_finish = 1'b0;
    logic [3:0]      rd_reg;
    logic [SW-1:0]   rd_data;
    logic            irq_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [SW-1:0] ref_m [NCH];

    always #4 clk = ~clk;   // 125 MHz

    chg_irq_agg u_chg_irq_agg (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_in   (stat_in),
        .mask_in   (mask_in),
        .rd_begin  (rd_begin),
        .rd_addr   (rd_addr),
        .rd_finish (rd_finish),
        .rd_reg    (rd_reg),
        .rd_data   (rd_data),
        .irq_pin   (irq_pin)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic model_irq();
        logic any = 1'b0;
        for (int c = 0; c < NCH; c++)
            any |= |((stat_in[c*SW +: SW] ^ ref_m[c]) & ~mask_in[c*SW +: SW]);
        return any;
    endfunction

    task automatic set_ch(input int c, input logic [SW-1:0] v);
        stat_in[c*SW +: SW] = v;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_open(input logic [3:0] a);
        rd_begin = 1'b1;
        rd_addr  = a;
        @(negedge clk);
        rd_begin = 1'b0;
    endtask

    task automatic rd_close(input int exp_reg, input logic [SW-1:0] exp_data);
        rd_finish = 1'b1;
        @(negedge clk);
        rd_finish = 1'b0;
        if (exp_reg < NCH) ref_m[exp_reg] = exp_data;
    endtask

    task automatic read_chk(input string tag, input logic [3:0] a,
                            input int exp_reg, input logic [SW-1:0] exp_data);
        rd_open(a);
        check({tag, " rd_reg"}, 32'(rd_reg), 32'(exp_reg));
        check({tag, " rd_data"}, 32'(rd_data), 32'(exp_data));
        rd_close(exp_reg, exp_data);
        check({tag, " irq after close"}, 32'(irq_pin), 32'(model_irq()));
    endtask

    task automatic t_reset();
        check("R4 reset irq", 32'(irq_pin), 0);
        check("R5 reset rd_reg", 32'(rd_reg), 0);
        check("R5 reset rd_data", 32'(rd_data), 0);
    endtask

    task automatic t_latency();
        set_ch(1, 8'h04);
        repeat (2) @(negedge clk);
        check("R1 irq not after two edges", 32'(irq_pin), 0);
        @(negedge clk);
        check("R1 irq after third edge", 32'(irq_pin), 1);
        read_chk("R4 summary shows ch1", 4'd4, 4, 8'h82);
        check("R4 summary read leaves irq", 32'(irq_pin), 1);
        read_chk("R5 direct read ch1", 4'd1, 1, 8'h04);
        check("R2 irq low after reference update", 32'(irq_pin), 0);
    endtask

    task automatic t_mask();
        mask_in[2*SW] = 1'b1;
        set_ch(2, 8'h01);
        settle();
        check("R3 masked change no irq", 32'(irq_pin), 0);
        read_chk("R3 summary omits masked", 4'd4, 4, 8'h00);
        set_ch(2, 8'h00);
        settle();
        mask_in[2*SW] = 1'b0;
        settle();
        check("R3 unmask after restore quiet", 32'(irq_pin), 0);
    endtask

    task automatic t_order();
        set_ch(3, 8'h0F);
        set_ch(0, 8'h00);
        ref_m[0] = 8'h00;
        set_ch(2, 8'h03);
        set_ch(0, 8'h20);
        settle();
        check("R7 irq with three pending", 32'(irq_pin), 1);
        read_chk("R6 first redirect ch0", 4'd15, 0, 8'h20);
        check("R7 irq after first", 32'(irq_pin), 1);
        read_chk("R7 second redirect ch2", 4'd15, 2, 8'h03);
        check("R7 irq after second", 32'(irq_pin), 1);
        read_chk("R7 third redirect ch3", 4'd15, 3, 8'h0F);
        check("R7 irq after last", 32'(irq_pin), 0);
    endtask

    task automatic t_empty();
        read_chk("R8 empty redirect summary", 4'd15, 4, 8'h00);
    endtask

    task automatic t_midread();
        set_ch(1, 8'h10);
        set_ch(2, 8'h01);
        settle();
        rd_open(4'd15);
        check("R6 midread resolves ch1", 32'(rd_reg), 1);
        check("R6 midread data", 32'(rd_data), 32'h10);
        set_ch(1, 8'h30);
        settle();
        check("R9 irq held while open", 32'(irq_pin), 1);
        check("R5 data frozen while open", 32'(rd_data), 32'h10);
        rd_close(1, 8'h10);
        check("R10 irq survives close", 32'(irq_pin), 1);
        read_chk("R10 summary ch1 ch2 pending", 4'd4, 4, 8'h86);
        read_chk("R10 ch1 again new value", 4'd15, 1, 8'h30);
        read_chk("R9 ch2 still pending", 4'd15, 2, 8'h01);
        check("R7 all read irq low", 32'(irq_pin), 0);
    endtask

    task automatic t_overlap();
        set_ch(0, 8'h80);
        set_ch(3, 8'h40);
        settle();
        rd_open(4'd15);
        check("R6 overlap first ch0", 32'(rd_reg), 0);
        rd_begin = 1'b1;
        rd_addr  = 4'd2;
        @(negedge clk);
        rd_begin = 1'b0;
        check("R11 busy begin ignored reg", 32'(rd_reg), 0);
        check("R11 busy begin ignored data", 32'(rd_data), 32'h80);
        rd_begin  = 1'b1;
        rd_finish = 1'b1;
        rd_addr   = 4'd15;
        @(negedge clk);
        rd_begin  = 1'b0;
        rd_finish = 1'b0;
        ref_m[0]  = 8'h80;
        check("R11 back to back skips cleared ch0", 32'(rd_reg), 3);
        check("R11 back to back data", 32'(rd_data), 32'h40);
        rd_close(3, 8'h40);
        check("R7 overlap irq low", 32'(irq_pin), 0);
    endtask

    task automatic t_badaddr();
        read_chk("R5 unmapped address zero", 4'd9, 9, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) ref_m[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_mask();
        t_order();
        t_empty();
        t_midread();
        t_overlap();
        t_badaddr();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule